// File: doc/BRIEF.md
# E3 Frame Parity Checker

This block sits on the receive side of an E3 link whose frame boundaries are already known. Serial bits arrive one per accepted cycle together with a marker on the first bit of each 1536-bit frame. The block folds every frame into a 4-bit interleaved parity word and holds it. When the next frame ends, it compares that stored word with the four bits that close the new frame, because the nibble a frame carries describes the frame before it.

A mismatch in any of the four lanes raises a one-cycle error pulse. The number of disagreeing lanes is added to a saturating error counter, which a strobe clears. Checking follows the same parity enable that the transmit side uses. A frame is only checked when a stored word from a complete preceding frame exists, so the first frame end after alignment, after a realignment or after the enable returns is skipped.

Top module: `e3_parity_checker`

## Requirements
- R1: After reset, `err_pulse` is low and `err_count` is zero.
- R2: A frame is 1536 accepted bits, with position 0 being the bit presented with `frame_mark`. Lane k (0..3) of the computed parity is the XOR of all bits at positions p with p mod 4 = k, over the whole frame. The received nibble is taken from positions 1532..1535, where position 1532+k holds lane k. A frame whose nibble equals the parity of the frame before it produces no error.
- R3: When the two words differ in any lane, `err_pulse` is high for exactly the one cycle after the clock edge that accepts position 1535, and is low at every other time.
- R4: The first frame end after the first `frame_mark` is not checked, whatever nibble it carries.
- R5: While `chk_en` is low, no pulse is raised and the count is unchanged. The first frame end after `chk_en` returns high is not checked either.
- R6: On a checked frame end, `err_count` grows by the number of lanes that differ (0 to 4). It changes at no other time, except through a clear.
- R7: `err_count` saturates at 2^CNT_W-1 and never wraps.
- R8: `cnt_clr` sets the count to zero at the next edge. If it coincides with a checked frame end, the count becomes that frame's mismatch count.
- R9: Cycles with `bit_en` low are ignored: the position does not advance and the parity state is held.
- R10: A `frame_mark` at a position other than 0 restarts the frame at position 0. The frame end that follows is not checked.
- R11: Bits accepted before the first `frame_mark` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_en | input | 1 | Parity checking enable |
| bit_en | input | 1 | Qualifies `bit_in` and `frame_mark` for this cycle |
| bit_in | input | 1 | Received serial bit |
| frame_mark | input | 1 | High on the first bit of a frame |
| cnt_clr | input | 1 | Clears the error counter |
| err_pulse | output | 1 | One-cycle parity error flag per frame |
| err_count | output | CNT_W | Saturating count of errored parity lanes |

## Verification
The assertions assume that `frame_mark` and `bit_in` only matter when `bit_en` is high. They also assume a frame is much longer than one cycle, so two frame ends can never be adjacent, and that `chk_en` and `cnt_clr` are ordinary synchronous levels. The stimulus drives every input one half period away from the active edge. It sends whole 1536-bit frames whose trailing nibble is built from the previous frame's parity, with chosen lanes flipped. Gaps in `bit_en`, a truncated frame and toggles of the enable are inserted only at the points where each requirement calls for them.

// File: rtl/e3par_pkg.sv
package e3par_pkg;

   typedef enum logic {
      REF_NONE  = 1'b0,
      REF_VALID = 1'b1
   } ref_state_e;

endpackage

// File: rtl/e3par_position.sv
module e3par_position #(
   parameter int FRAME_BITS = 1536,
   localparam int POS_W     = $clog2(FRAME_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             frame_mark,
   output logic             take,
   output logic [POS_W-1:0] pos_cur,
   output logic             last_bit,
   output logic             misalign
);

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

   logic [POS_W-1:0] pos_q;
   logic             locked_q;

   assign take     = bit_en & (frame_mark | locked_q);
   assign pos_cur  = frame_mark ? '0 : pos_q;
   assign last_bit = take & (pos_cur == LAST_POS);
   assign misalign = take & frame_mark & locked_q & (pos_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q    <= '0;
         locked_q <= 1'b0;
      end else if (take) begin
         locked_q <= 1'b1;
         pos_q    <= (pos_cur == LAST_POS) ? '0 : pos_cur + 1'b1;
      end
   end

endmodule

// File: rtl/e3par_lanes.sv
module e3par_lanes #(
   parameter int FRAME_BITS = 1536,
   parameter int LANES      = 4,
   localparam int POS_W     = $clog2(FRAME_BITS),
   localparam int LW        = $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [POS_W-1:0] pos_cur,
   input  logic             din,
   output logic [LANES-1:0] par_now,
   output logic [LANES-1:0] rx_now
);

   logic frame_first;
   assign frame_first = (pos_cur == '0);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int               RX_POS = FRAME_BITS - LANES + k;
      localparam logic [POS_W-1:0] RX_AT  = POS_W'(RX_POS);

      logic hit;
      logic acc_q;

      assign hit        = (pos_cur[LW-1:0] == LW'(k));
      assign par_now[k] = acc_q ^ (hit & din);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_q <= 1'b0;
         end else if (take) begin
            if (frame_first) acc_q <= hit & din;
            else if (hit)    acc_q <= acc_q ^ din;
         end
      end

      if (k == LANES - 1) begin : g_live
         assign rx_now[k] = din;
      end else begin : g_held
         logic rx_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          rx_q <= 1'b0;
            else if (take && pos_cur == RX_AT)   rx_q <= din;
         end
         assign rx_now[k] = rx_q;
      end
   end

endmodule

// File: rtl/e3par_satcount.sv
module e3par_satcount #(
   parameter int CNT_W  = 16,
   parameter int ADD_W  = 3,
   localparam int SUM_W = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [ADD_W-1:0] add,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [SUM_W-1:0] TOP = SUM_W'({CNT_W{1'b1}});

   logic [SUM_W-1:0] sum;

   always_comb begin
      sum = (clr ? '0 : SUM_W'(cnt)) + SUM_W'(add);
      if (sum > TOP) sum = TOP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= sum[CNT_W-1:0];
   end

endmodule

// File: rtl/e3_parity_checker.sv
module e3_parity_checker
   import e3par_pkg::*;
#(
   parameter int FRAME_BITS = 1536,
   parameter int LANES      = 4,
   parameter int CNT_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chk_en,
   input  logic             bit_en,
   input  logic             bit_in,
   input  logic             frame_mark,
   input  logic             cnt_clr,
   output logic             err_pulse,
   output logic [CNT_W-1:0] err_count
);

   localparam int POS_W = $clog2(FRAME_BITS);
   localparam int ADD_W = $clog2(LANES + 1);

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two of at least 2");
   end
   if (FRAME_BITS % LANES != 0 || FRAME_BITS < 4 * LANES) begin : g_bad_frame
      $error("FRAME_BITS must be a multiple of LANES and at least 4*LANES");
   end
   if (CNT_W < 2 || CNT_W > 31) begin : g_bad_cnt
      $error("CNT_W must be between 2 and 31");
   end

   logic             take, last_bit, misalign;
   logic [POS_W-1:0] pos_cur;
   logic [LANES-1:0] par_now, rx_now, ref_par_q, mism;
   logic [ADD_W-1:0] n_bad;
   logic             check;
   ref_state_e       ref_st_q;

   e3par_position #(.FRAME_BITS(FRAME_BITS)) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_en     (bit_en),
      .frame_mark (frame_mark),
      .take       (take),
      .pos_cur    (pos_cur),
      .last_bit   (last_bit),
      .misalign   (misalign)
   );

   e3par_lanes #(.FRAME_BITS(FRAME_BITS), .LANES(LANES)) u_lanes (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .pos_cur (pos_cur),
      .din     (bit_in),
      .par_now (par_now),
      .rx_now  (rx_now)
   );

   assign check = last_bit & chk_en & (ref_st_q == REF_VALID);
   assign mism  = check ? (ref_par_q ^ rx_now) : '0;
   assign n_bad = ADD_W'($countones(mism));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_st_q  <= REF_NONE;
         ref_par_q <= '0;
         err_pulse <= 1'b0;
      end else begin
         err_pulse <= |mism;
         if (last_bit) begin
            ref_par_q <= par_now;
            ref_st_q  <= chk_en ? REF_VALID : REF_NONE;
         end else if (!chk_en || misalign) begin
            ref_st_q  <= REF_NONE;
         end
      end
   end

   e3par_satcount #(.CNT_W(CNT_W), .ADD_W(ADD_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .add   (n_bad),
      .cnt   (err_count)
   );

endmodule

// File: rtl/e3par_checker.sv
module e3par_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             chk_en,
   input logic             bit_en,
   input logic             cnt_clr,
   input logic             err_pulse,
   input logic [CNT_W-1:0] err_count
);

   // R3: a pulse never lasts two cycles
   p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |=> !err_pulse);

   // R9: a pulse needs an accepted bit on the edge before
   p_pulse_after_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> $past(bit_en));

   // R5: no pulse from a disabled cycle
   p_pulse_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> $past(chk_en));

   // R7: without a clear the count never goes down
   p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cnt_clr) |-> err_count >= $past(err_count));

   // R6: count moves only together with a pulse
   p_cnt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cnt_clr) && !err_pulse) |-> $stable(err_count));

   // R8: a clear with no coincident error leaves zero
   p_clr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt_clr) && !err_pulse) |-> err_count == '0);

endmodule

bind e3_parity_checker e3par_checker #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .chk_en    (chk_en),
   .bit_en    (bit_en),
   .cnt_clr   (cnt_clr),
   .err_pulse (err_pulse),
   .err_count (err_count)
);

// File: tb/tb_e3_parity_checker.sv
`timescale 1ns/1ps
module tb_e3_parity_checker;

   localparam int FB    = 1536;
   localparam int CW    = 5;
   localparam int CMAX  = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chk_en = 1'b0, bit_en = 1'b0, bit_in = 1'b0;
   logic          frame_mark = 1'b0, cnt_clr = 1'b0;
   logic          err_pulse;
   logic [CW-1:0] err_count;

   always #2 clk = ~clk;

   e3_parity_checker #(.FRAME_BITS(FB), .LANES(4), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .bit_en(bit_en),
      .bit_in(bit_in), .frame_mark(frame_mark), .cnt_clr(cnt_clr),
      .err_pulse(err_pulse), .err_count(err_count)
   );

   int n_checks = 0, n_errors = 0, pulses = 0;
   bit done = 0;

   // reference model state
   int m_pos = 0, m_cnt = 0;
   bit m_lock = 0, m_ref = 0, m_err = 0;
   bit m_acc[4], m_rx[4], m_prev[4];
   bit [3:0] tx_prev = 4'h0;

   task automatic check_eq(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input bit b, input bit sof, input bit en,
                       input bit clr, input bit ben);
      int nmis;
      bit mis;
      @(negedge clk);
      check_eq("R3 pulse vs model", int'(err_pulse), int'(m_err));
      check_eq("R6 count vs model", int'(err_count), m_cnt);
      if (err_pulse) pulses++;
      bit_in = b; frame_mark = sof; chk_en = en; cnt_clr = clr; bit_en = ben;
      nmis = 0; mis = 0;
      if (ben && (sof || m_lock)) begin
         int p;
         p = sof ? 0 : m_pos;
         if (sof && m_lock && m_pos != 0) mis = 1;
         if (p == 0) for (int k = 0; k < 4; k++) m_acc[k] = 0;
         m_acc[p % 4] ^= b;
         if (p >= FB - 4) m_rx[p - (FB - 4)] = b;
         if (p == FB - 1) begin
            if (en && m_ref)
               for (int k = 0; k < 4; k++) if (m_prev[k] != m_rx[k]) nmis++;
            for (int k = 0; k < 4; k++) m_prev[k] = m_acc[k];
            m_ref = en;
         end
         m_pos = (p == FB - 1) ? 0 : p + 1;
         m_lock = 1;
      end
      if (!en || mis) m_ref = 0;
      if (clr) m_cnt = 0;
      m_cnt += nmis;
      if (m_cnt > CMAX) m_cnt = CMAX;
      m_err = (nmis > 0);
   endtask

   task automatic idle(input bit en);
      step(1'b0, 1'b0, en, 1'b0, 1'b0);
   endtask

   // one frame; trailer = parity of previous frame sent, lanes in emask flipped
   task automatic send_frame(input bit [3:0] emask, input bit en,
                             input int gap_every, input bit clr_last);
      bit [3:0] par;
      par = 4'h0;
      for (int i = 0; i < FB; i++) begin
         bit b;
         if (i >= FB - 4) b = tx_prev[i - (FB - 4)] ^ emask[i - (FB - 4)];
         else             b = 1'($urandom);
         par[i % 4] ^= b;
         if (gap_every > 0 && i % gap_every == 3) begin
            step(~b, 1'b1, en, 1'b0, 1'b0);  // ignored cycle, garbage on inputs
            step(~b, 1'b0, en, 1'b0, 1'b0);
         end
         step(b, i == 0, en, clr_last && i == FB - 1, 1'b1);
      end
      tx_prev = par;
   endtask

   initial begin
      int p0;
      repeat (3) @(negedge clk);
      check_eq("R1 reset pulse", int'(err_pulse), 0);
      check_eq("R1 reset count", int'(err_count), 0);
      rst_n = 1'b1;

      // R11: bits before any frame marker
      for (int i = 0; i < 100; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
      idle(1);
      check_eq("R11 pre-sync ignored", int'(err_count), 0);

      // R4: first frame unchecked even with all lanes wrong
      send_frame(4'hF, 1, 0, 0);
      idle(1);
      check_eq("R4 first frame skipped", int'(err_count), 0);

      // R2: clean frames
      send_frame(4'h0, 1, 0, 0);
      send_frame(4'h0, 1, 0, 0);
      idle(1);
      check_eq("R2 clean frames", int'(err_count), 0);

      // R3, R6: two lanes wrong, one pulse
      p0 = pulses;
      send_frame(4'h5, 1, 0, 0);
      idle(1);
      check_eq("R3 single pulse", pulses - p0, 1);
      check_eq("R6 two lanes", int'(err_count), 2);

      // R9: gaps in bit_en
      send_frame(4'h8, 1, 7, 0);
      idle(1);
      check_eq("R9 gaps ignored", int'(err_count), 3);

      // R5: disabled frame, then first enabled frame skipped
      send_frame(4'hF, 0, 0, 0);
      idle(0);
      check_eq("R5 disabled", int'(err_count), 3);
      send_frame(4'hF, 1, 0, 0);
      idle(1);
      check_eq("R5 re-enable skip", int'(err_count), 3);
      send_frame(4'h2, 1, 0, 0);
      idle(1);
      check_eq("R5 checking resumes", int'(err_count), 4);

      // R10: truncated frame then early marker
      for (int i = 0; i < 500; i++) step(1'($urandom), i == 0, 1'b1, 1'b0, 1'b1);
      send_frame(4'hF, 1, 0, 0);
      idle(1);
      check_eq("R10 realign skip", int'(err_count), 4);
      send_frame(4'h1, 1, 0, 0);
      idle(1);
      check_eq("R10 after realign", int'(err_count), 5);

      // R8: clear together with an errored frame end, then plain clear
      send_frame(4'hF, 1, 0, 1);
      idle(1);
      check_eq("R8 clear with error", int'(err_count), 4);
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
      idle(1);
      check_eq("R8 plain clear", int'(err_count), 0);

      // R7: saturation
      for (int f = 0; f < 9; f++) send_frame(4'hF, 1, 0, 0);
      idle(1);
      check_eq("R7 saturated", int'(err_count), CMAX);

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1;
         n_checks++; n_errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule